// File: doc/BRIEF.md
# Dual-Channel Sequential Read Prefetcher

This engine fetches runs of consecutive items from an external device in the background and pushes each returned item into a shared read FIFO. It has two channels. Each channel keeps its own item width and its own next-address pointer. Software writes a non-zero item count to start a channel. The engine then issues one read request per item on a simple request/response port and advances that channel's pointer by the item width. Each item is zero-extended to 32 bits before it is pushed.

When the FIFO reports full, the engine stops issuing requests and resumes by itself once space frees up. A pointer survives the end of a transfer, so a later start on the same channel continues from the next address. Writing a count of zero cancels a channel. If both channels are waiting, channel 0 goes first. A channel that has already begun a transfer keeps the port until that transfer ends.

Top module: `dual_read_prefetcher`

## Requirements
- R1: While `rst` is high, and after it is released, `remain0` and `remain1` read 0 and `req_valid` and `fifo_push` stay low until a count is written.
- R2: A `cnt_we` write of a value from 1 to 4095 to channel `cnt_ch` loads that value into the channel's remaining-count output. The count falls by one for each item pushed, and the channel issues exactly that many requests.
- R3: Item width code 0 selects 8-bit items, code 1 selects 16-bit items, and codes 2 and 3 select 32-bit items. Successive requests of a transfer carry addresses that step by 1, 2 or 4 bytes, starting at the channel's pointer.
- R4: Each pushed item is the low 8, 16 or 32 bits of `rsp_data`, selected by the channel's width code, with all higher bits cleared.
- R5: No request starts while `fifo_full` is high or in the cycle in which `fifo_push` is high. No push occurs while `fifo_full` is high. A stalled transfer resumes without any new write once `fifo_full` falls.
- R6: When a transfer ends, the channel's pointer rests one item past the last item read. A new count write without reconfiguration continues from there.
- R7: A count write of 0 sets the channel's remaining count to 0 and stops further requests for it. If its request is outstanding, that item is discarded and not pushed, and its address is not consumed.
- R8: When both channels have work and neither transfer has begun, channel 0 is served first.
- R9: A transfer that has begun runs to completion before the other channel issues any request, even if the other channel was started later.
- R10: A configuration write (`cfg_we`) to a channel whose remaining count is non-zero is ignored. Its width and pointer keep their old values.
- R11: `req_valid` stays high with a stable `req_addr` and `req_size` until `req_ready` is sampled high. At most one request is outstanding. A push follows in the cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel addressed by the configuration write |
| cfg_size | input | 2 | Item width code (0: 8, 1: 16, 2/3: 32 bits) |
| cfg_addr | input | ADDR_W | Start address relative to the device |
| cnt_we | input | 1 | Count write strobe (non-zero starts, zero cancels) |
| cnt_ch | input | 1 | Channel addressed by the count write |
| cnt_val | input | CNT_W | Item count |
| remain0 | output | CNT_W | Items still to read on channel 0 |
| remain1 | output | CNT_W | Items still to read on channel 1 |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | ADDR_W | Read request address |
| req_size | output | 2 | Read request width code |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data, item in the low bits |
| fifo_full | input | 1 | Read FIFO cannot accept an item |
| fifo_push | output | 1 | Push strobe into the read FIFO |
| fifo_data | output | 32 | Zero-extended item |

## Verification
The hardest case to reach is a cancel that arrives while a request is already on the bus. The bench waits until it sees a request accepted, then writes the zero count before the delayed response returns. It then restarts the channel and confirms that the dropped address is requested again. The ordering cases need both channels pending at once. To get there, the bench holds the model FIFO full so that nothing can issue, starts both channels, and only then lets the FIFO drain. Address stepping and zero extension are swept over every width code on both channels, with expected items computed from a fixed address pattern.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;
  localparam int ITEM_W = 32;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_st_t;

  function automatic logic [2:0] size_step(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [ITEM_W-1:0] size_zext(input logic [ITEM_W-1:0] d,
                                                  input logic [1:0] code);
    case (code)
      2'd0:    return {24'd0, d[7:0]};
      2'd1:    return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/rdpf_channel.sv
module rdpf_channel
  import rdpf_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_size,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic [1:0]        size,
  output logic [CNT_W-1:0]  remain
);
  logic idle_ch;
  assign idle_ch = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      size   <= 2'd0;
      remain <= '0;
    end else begin
      if (cfg_we && idle_ch) begin
        ptr  <= cfg_addr;
        size <= cfg_size;
      end
      if (cnt_we) begin
        remain <= cnt_val;
      end else if (adv) begin
        remain <= remain - 1'b1;
        ptr    <= ptr + ADDR_W'(size_step(size));
      end
    end
  end
endmodule

// File: rtl/rdpf_seq.sv
module rdpf_seq
  import rdpf_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int CNT_W  = 12,
  parameter int NCH    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCH-1:0][ADDR_W-1:0] ch_ptr,
  input  logic [NCH-1:0][1:0]        ch_size,
  input  logic [NCH-1:0][CNT_W-1:0]  ch_remain,
  input  logic                       cnt_we,
  input  logic                       cnt_ch,
  input  logic [CNT_W-1:0]           cnt_val,
  output logic [NCH-1:0]             adv,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [ADDR_W-1:0]          req_addr,
  output logic [1:0]                 req_size,
  input  logic                       rsp_valid,
  input  logic [ITEM_W-1:0]          rsp_data,
  input  logic                       fifo_full,
  output logic                       fifo_push,
  output logic [ITEM_W-1:0]          fifo_data
);
  seq_st_t      st;
  logic         cur, lock, drop, sel, hit, good, can_issue;
  logic [NCH-1:0] busy;

  for (genvar g = 0; g < NCH; g++) begin : g_busy
    assign busy[g] = (ch_remain[g] != '0);
    assign adv[g]  = good && (cur == 1'(g));
  end

  assign hit       = cnt_we && (cnt_ch == cur);
  assign good      = (st == S_WAIT) && rsp_valid && !drop && !hit;
  assign sel       = (lock && busy[cur]) ? cur : !busy[0];
  assign can_issue = (st == S_IDLE) && (busy != '0) && !fifo_full && !fifo_push;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur       <= 1'b0;
      lock      <= 1'b0;
      drop      <= 1'b0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_size  <= 2'd0;
      fifo_push <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_push <= good;
      if (good) fifo_data <= size_zext(rsp_data, ch_size[cur]);
      if ((good && ch_remain[cur] == CNT_W'(1)) || (hit && cnt_val == '0))
        lock <= 1'b0;
      case (st)
        S_IDLE: begin
          if (can_issue) begin
            cur       <= sel;
            lock      <= 1'b1;
            drop      <= cnt_we && (cnt_ch == sel);
            req_valid <= 1'b1;
            req_addr  <= ch_ptr[sel];
            req_size  <= ch_size[sel];
            st        <= S_REQ;
          end
        end
        S_REQ: begin
          if (hit) drop <= 1'b1;
          if (req_ready) begin
            req_valid <= 1'b0;
            st        <= S_WAIT;
          end
        end
        default: begin
          if (hit) drop <= 1'b1;
          if (rsp_valid) st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_read_prefetcher.sv
module dual_read_prefetcher
  import rdpf_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_ch,
  input  logic [1:0]        cfg_size,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cnt_we,
  input  logic              cnt_ch,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [CNT_W-1:0]  remain0,
  output logic [CNT_W-1:0]  remain1,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [31:0]       fifo_data
);
  localparam int NCH = 2;

  logic [NCH-1:0][ADDR_W-1:0] ch_ptr;
  logic [NCH-1:0][1:0]        ch_size;
  logic [NCH-1:0][CNT_W-1:0]  ch_remain;
  logic [NCH-1:0]             adv;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rdpf_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we && (cfg_ch == 1'(g))),
      .cfg_size (cfg_size),
      .cfg_addr (cfg_addr),
      .cnt_we   (cnt_we && (cnt_ch == 1'(g))),
      .cnt_val  (cnt_val),
      .adv      (adv[g]),
      .ptr      (ch_ptr[g]),
      .size     (ch_size[g]),
      .remain   (ch_remain[g])
    );
  end

  assign remain0 = ch_remain[0];
  assign remain1 = ch_remain[1];

  rdpf_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NCH(NCH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ch_ptr    (ch_ptr),
    .ch_size   (ch_size),
    .ch_remain (ch_remain),
    .cnt_we    (cnt_we),
    .cnt_ch    (cnt_ch),
    .cnt_val   (cnt_val),
    .adv       (adv),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .fifo_full (fifo_full),
    .fifo_push (fifo_push),
    .fifo_data (fifo_data)
  );
endmodule

// File: rtl/dual_read_prefetcher_chk.sv
module dual_read_prefetcher_chk #(
  parameter int ADDR_W = 29,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_we,
  input logic [CNT_W-1:0]  remain0,
  input logic [CNT_W-1:0]  remain1,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              fifo_full,
  input logic              fifo_push
);
  assert_hold_req_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_size)));

  assert_push_after_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> $past(rsp_valid));

  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !fifo_full);

  assert_no_start_full_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> !$past(fifo_full));

  assert_remain0_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> (remain0 <= $past(remain0)));

  assert_remain1_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> (remain1 <= $past(remain1)));

  assert_push_counts_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> ((remain0 != $past(remain0)) || (remain1 != $past(remain1))));
endmodule

bind dual_read_prefetcher dual_read_prefetcher_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_we    (cnt_we),
  .remain0   (remain0),
  .remain1   (remain1),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .fifo_full (fifo_full),
  .fifo_push (fifo_push)
);

// File: tb/tb_dual_read_prefetcher.sv
module tb_dual_read_prefetcher;
  localparam int ADDR_W = 29;
  localparam int CNT_W  = 12;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              cfg_we = 0, cfg_ch = 0, cnt_we = 0, cnt_ch = 0;
  logic [1:0]        cfg_size = 0;
  logic [ADDR_W-1:0] cfg_addr = 0;
  logic [CNT_W-1:0]  cnt_val = 0;
  logic [CNT_W-1:0]  remain0, remain1;
  logic              req_valid, req_ready, rsp_valid, fifo_full, fifo_push;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [31:0]       rsp_data, fifo_data;

  dual_read_prefetcher #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

  int n_tests = 0, n_fail = 0;
  int rsp_lat = 1;
  logic slow_ready = 0, drain_en = 1;
  logic ready_q, pend;
  int lat, fcnt;
  logic [ADDR_W-1:0] paddr;
  logic [31:0] got[$], expq[$];
  int acc_log[$], expa[$];
  int eaddr[2];
  int esize[2];

  function automatic logic [31:0] pat(input int a);
    logic [7:0] b0, b1;
    b0 = a[7:0]; b1 = a[15:8];
    return {b0 ^ 8'h5A, ~b0, b1 + 8'h3C, b0};
  endfunction
  function automatic logic [31:0] ext(input logic [31:0] d, input int s);
    if (s == 0) return d & 32'hFF;
    if (s == 1) return d & 32'hFFFF;
    return d;
  endfunction
  function automatic int stp(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  assign req_ready = slow_ready ? ready_q : 1'b1;
  assign fifo_full = (fcnt == DEPTH);

  always @(posedge clk) begin
    if (rst) begin
      pend <= 0; lat <= 0; rsp_valid <= 0; rsp_data <= 0; ready_q <= 0; fcnt <= 0;
    end else begin
      ready_q <= ~ready_q;
      rsp_valid <= 0;
      if (pend) begin
        if (lat == 0) begin rsp_valid <= 1; rsp_data <= pat(int'(paddr)); pend <= 0; end
        else lat <= lat - 1;
      end else if (req_valid && req_ready) begin
        pend <= 1; paddr <= req_addr; lat <= rsp_lat; acc_log.push_back(int'(req_addr));
      end
      fcnt <= fcnt + (fifo_push ? 1 : 0) - ((drain_en && fcnt > 0) ? 1 : 0);
      if (fifo_push) got.push_back(fifo_data);
      if (fifo_push && fcnt == DEPTH) begin
        n_tests++; n_fail++; $display("FAIL R5 push into full FIFO actual=1 expected=0");
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input int ch, input int s, input int a);
    @(negedge clk); cfg_we = 1; cfg_ch = ch[0]; cfg_size = s[1:0]; cfg_addr = ADDR_W'(a);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic do_cnt(input int ch, input int v);
    @(negedge clk); cnt_we = 1; cnt_ch = ch[0]; cnt_val = CNT_W'(v);
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic model_cfg(input int ch, input int s, input int a);
    esize[ch] = s; eaddr[ch] = a;
  endtask
  task automatic add_items(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      expa.push_back(eaddr[ch]);
      expq.push_back(ext(pat(eaddr[ch]), esize[ch]));
      eaddr[ch] += stp(esize[ch]);
    end
  endtask
  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (remain0 == 0 && remain1 == 0 && !pend && !req_valid && !rsp_valid && !fifo_push)
        quiet++;
      else quiet = 0;
    end
  endtask
  task automatic compare(input string tag);
    chk({tag, " item count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk({tag, " item"}, got[i], expq[i]);
    chk({tag, " request count"}, acc_log.size(), expa.size());
    for (int i = 0; i < expa.size() && i < acc_log.size(); i++)
      chk({tag, " request address"}, acc_log[i], expa[i]);
    got.delete(); expq.delete(); acc_log.delete(); expa.delete();
  endtask
  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs idle while in reset and just after release
    chk("R1 remain0 in reset", remain0, 0);
    chk("R1 req_valid in reset", req_valid, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk("R1 remain0", remain0, 0);
    chk("R1 remain1", remain1, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 fifo_push", fifo_push, 0);

    // R3 R4: sweep width codes and counts on both channels
    for (int ch = 0; ch < 2; ch++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 2; k++) begin
          int n = (k == 0) ? 1 : 3;
          int a = ch * 256 + s * 16 + 1 + k * 64;
          rsp_lat = (s + k) % 3;
          slow_ready = s[0];
          do_cfg(ch, s, a); model_cfg(ch, s, a);
          do_cnt(ch, n); add_items(ch, n);
          wait_idle();
          compare("R3 R4 R2 sweep");
        end
    slow_ready = 0; rsp_lat = 0;

    // R2: largest count on an 8-bit channel
    do_cfg(0, 0, 32'h1000_0000); model_cfg(0, 0, 32'h1000_0000);
    do_cnt(0, 4095); add_items(0, 4095);
    @(negedge clk);
    chk("R2 remain loaded", (remain0 <= 4095 && remain0 >= 4090) ? 1 : 0, 1);
    wait_idle();
    compare("R2 max count");

    // R5: backpressure with drain stopped
    drain_en = 0; rsp_lat = 1;
    do_cfg(1, 2, 32'h40); model_cfg(1, 2, 32'h40);
    do_cnt(1, 10);
    repeat (60) @(negedge clk);
    chk("R5 remain1 stalled", remain1, 6);
    chk("R5 items pushed", got.size(), DEPTH);
    chk("R5 no request while full", pend || req_valid, 0);
    // R7: cancel stalled transfer
    do_cnt(1, 0);
    chk("R7 remain1 after cancel", remain1, 0);
    drain_en = 1;
    wait_idle();
    chk("R7 no push after cancel", got.size(), DEPTH);
    add_items(1, 4);
    compare("R5 R7 backpressure");
    // R6: continue from next address
    do_cnt(1, 1); add_items(1, 1);
    wait_idle();
    compare("R6 continue");

    // R5 resume: stall then drain without new writes
    drain_en = 0;
    do_cfg(0, 1, 32'h500); model_cfg(0, 1, 32'h500);
    do_cnt(0, 7); add_items(0, 7);
    repeat (40) @(negedge clk);
    chk("R5 remain0 stalled", remain0, 3);
    drain_en = 1;
    wait_idle();
    compare("R5 resume");

    // R7: cancel with a request outstanding
    rsp_lat = 4;
    do_cfg(0, 1, 100); model_cfg(0, 1, 100);
    @(negedge clk); cnt_we = 1; cnt_ch = 0; cnt_val = 3;
    @(negedge clk); cnt_we = 0;
    while (acc_log.size() == 0) @(negedge clk);
    cnt_we = 1; cnt_ch = 0; cnt_val = 0;
    @(negedge clk); cnt_we = 0;
    wait_idle();
    chk("R7 in-flight item dropped", got.size(), 0);
    expa.push_back(100);
    do_cnt(0, 2); add_items(0, 2);
    wait_idle();
    compare("R7 in-flight cancel");
    rsp_lat = 1;

    // R8: both pending, channel 0 first
    drain_en = 0;
    do_cfg(0, 0, 7); model_cfg(0, 0, 7);
    do_cnt(0, 4); add_items(0, 4);
    repeat (40) @(negedge clk);
    do_cfg(1, 1, 32'h200); model_cfg(1, 1, 32'h200);
    do_cnt(1, 2);
    do_cnt(0, 2);
    repeat (5) @(negedge clk);
    chk("R8 held while full", got.size(), 4);
    add_items(0, 2); add_items(1, 2);
    drain_en = 1;
    wait_idle();
    compare("R8 priority");

    // R9 R10: later channel 0 waits; config of busy channel 1 ignored
    rsp_lat = 3; slow_ready = 1;
    do_cfg(1, 2, 32'h1000); model_cfg(1, 2, 32'h1000);
    do_cnt(1, 5); add_items(1, 5);
    while (acc_log.size() == 0) @(negedge clk);
    do_cfg(1, 0, 32'h2000);
    do_cfg(0, 2, 32'h3000); model_cfg(0, 2, 32'h3000);
    do_cnt(0, 2); add_items(0, 2);
    wait_idle();
    compare("R9 R10 no preempt");
    // R10: ignored config left channel 1 pointer and width intact
    slow_ready = 0; rsp_lat = 0;
    do_cnt(1, 1); add_items(1, 1);
    wait_idle();
    compare("R10 pointer kept");
    // R11: handshake is checked by the bound properties during all of the above
    chk("R11 request idle at end", req_valid, 0);

    finish_run();
  end
endmodule